// File: doc/BRIEF.md
# VLIW Operation Dispersal Unit

This block sits between instruction fetch and the execution units of a wide-issue processor whose instruction bundles are compressed: a bundle carries only the operations it really needs, with no filler words. Operations arrive one 32-bit word per transfer on a valid/ready stream. The unit gathers words until it sees one marked as the last of its bundle. It then presents the whole bundle at once, with every operation already placed in the execution slot that matches its unit class.

There are six output slots. Slots 0 and 1 feed the memory (load/store) units, slots 2 and 3 the simple integer units, slot 4 the complex integer unit and slot 5 the branch/compare unit. Each slot has a valid flag and a 32-bit operation word. Two error flags travel with the bundle. One reports that a class asked for more slots than it has. The other reports that a bundle ran past its maximum length without a closing word. While a finished bundle waits for the consumer, the input stream is stalled.

Top module: `vliw_disperse`

## Requirements
- R1: Bit 31 of an operation word is the end-of-bundle marker; the cycle after a word with bit 31 set is accepted, `out_valid` is high.
- R2: Bits 30:29 give the unit class (0 memory, 1 simple integer, 2 complex integer, 3 branch/compare), and an operation is placed only in its class's slots: memory in 0–1, simple in 2–3, complex in 4, branch in 5.
- R3: Operations of one class take that class's slots in arrival order, lowest slot index first, whatever other classes are interleaved between them.
- R4: A released bundle shows valid flags only for slots that received an operation; unused slots read valid 0 and word 0, so a bundle of any length from one to six words is carried without filler.
- R5: An operation whose class has no free slot left is dropped and sets `out_oversub` on that bundle; the bundle still closes at its end marker and keeps the operations that did fit.
- R6: If a seventh word arrives while six words of the bundle are already accepted without an end marker, that word is consumed and discarded, and the bundle is released at once with `out_overlen` set and its first six words in place.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every bundle output holds its value.
- R8: The cycle after a bundle is taken (`out_valid` and `out_ready` both high), `out_valid` is low, `in_ready` is high, and all slot valid flags and error flags are clear.
- R9: During reset `out_valid`, all slot valid flags and both error flags are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation word is offered |
| in_ready | output | 1 | The unit takes the offered word this cycle |
| in_op | input | 32 | Operation word: bit 31 end marker, bits 30:29 unit class |
| out_valid | output | 1 | A complete bundle is on the outputs |
| out_ready | input | 1 | The consumer takes the bundle this cycle |
| out_vld | output | 6 | Per-slot valid flags, bit i for slot i |
| out_ops | output | 192 | Per-slot operation words, slot i in bits 32*i+31 : 32*i |
| out_oversub | output | 1 | A class ran out of slots in this bundle |
| out_overlen | output | 1 | The bundle was forced closed by a seventh word |

## Verification
The embedded properties assume the consumer follows the ready/valid rule on the output side: a held bundle is judged stable only while `out_ready` is low, and the clearing check assumes that no new word is taken on the same edge a bundle leaves, which the stall on `in_ready` guarantees. They also take for granted that `in_op` carries meaningful class bits whenever `in_valid` is high. The stimulus keeps to this by changing inputs only on the falling clock edge. It raises `in_valid` only after it has seen `in_ready` high, and it drives `out_ready` for exactly one cycle per bundle, after any stall interval it chooses.

// File: rtl/vliw_disperse.sv
module vliw_disperse #(
  parameter int N_LS    = 2,
  parameter int N_SI    = 2,
  parameter int N_CX    = 1,
  parameter int N_BR    = 1,
  parameter int MAX_OPS = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [31:0]                    in_op,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [N_LS+N_SI+N_CX+N_BR-1:0] out_vld,
  output logic [32*(N_LS+N_SI+N_CX+N_BR)-1:0] out_ops,
  output logic                           out_oversub,
  output logic                           out_overlen
);

  localparam int NSLOT = N_LS + N_SI + N_CX + N_BR;
  localparam int CW    = $clog2(NSLOT + MAX_OPS + 1);

  logic [NSLOT-1:0] slot_v;
  logic [31:0]      slot_op [NSLOT];
  logic [CW-1:0]    cnt [4];
  logic [CW-1:0]    n_ops;
  logic             pend, oversub_q, overlen_q;

  logic [1:0]    cls;
  logic [CW-1:0] cap_sel, base_sel, tgt;
  logic          fire, take, room, force_end;

  assign cls       = in_op[30:29];
  assign in_ready  = !pend;
  assign fire      = in_valid && in_ready;
  assign take      = out_valid && out_ready;
  assign force_end = fire && (n_ops == CW'(MAX_OPS));

  always_comb begin
    case (cls)
      2'd0:    begin cap_sel = CW'(N_LS); base_sel = CW'(0); end
      2'd1:    begin cap_sel = CW'(N_SI); base_sel = CW'(N_LS); end
      2'd2:    begin cap_sel = CW'(N_CX); base_sel = CW'(N_LS + N_SI); end
      default: begin cap_sel = CW'(N_BR); base_sel = CW'(N_LS + N_SI + N_CX); end
    endcase
  end

  assign room = cnt[cls] < cap_sel;
  assign tgt  = base_sel + cnt[cls];

  always_ff @(posedge clk) begin
    if (!rst_n || take) begin
      pend      <= 1'b0;
      oversub_q <= 1'b0;
      overlen_q <= 1'b0;
      n_ops     <= '0;
      slot_v    <= '0;
      for (int c = 0; c < 4; c++) cnt[c] <= '0;
      for (int s = 0; s < NSLOT; s++) slot_op[s] <= '0;
    end else if (fire) begin
      if (force_end) begin
        overlen_q <= 1'b1;
        pend      <= 1'b1;
      end else begin
        n_ops <= n_ops + 1'b1;
        if (room) begin
          cnt[cls] <= cnt[cls] + 1'b1;
          for (int s = 0; s < NSLOT; s++)
            if (tgt == CW'(s)) begin
              slot_v[s]  <= 1'b1;
              slot_op[s] <= in_op;
            end
        end else begin
          oversub_q <= 1'b1;
        end
        if (in_op[31]) pend <= 1'b1;
      end
    end
  end

  assign out_valid   = pend;
  assign out_vld     = slot_v;
  assign out_oversub = oversub_q;
  assign out_overlen = overlen_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_pack
    assign out_ops[32*s +: 32] = slot_op[s];
  end

  assert_close_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op[31]) |=> out_valid);

  assert_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && n_ops == CW'(MAX_OPS)) |=> (out_valid && out_overlen));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_vld) && $stable(out_ops)
                                   && $stable(out_oversub) && $stable(out_overlen)));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && out_vld == '0 && !out_oversub && !out_overlen));

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_oversub && !out_valid) |=> out_oversub);

endmodule

// File: tb/sim_vliw_disperse.sv
module sim_vliw_disperse;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [5:0]   vld;
    logic [191:0] ops;
    logic         osub;
    logic         olen;
  } exp_t;

  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 0;
  logic [31:0] in_op = '0;
  logic in_ready, out_valid, out_oversub, out_overlen;
  logic [5:0] out_vld;
  logic [191:0] out_ops;

  int n_chk = 0, n_fail = 0;
  exp_t exp_q[$];
  int stall_req = 0;

  vliw_disperse u0 (.clk, .rst_n, .in_valid, .in_ready, .in_op, .out_valid, .out_ready,
                    .out_vld, .out_ops, .out_oversub, .out_overlen);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit stop, input logic [1:0] c, input logic [28:0] pay);
    return {stop, c, pay};
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Model from R2..R6: slot base per class 0,2,4,5; capacity 2,2,1,1; six words max.
  task automatic send(input logic [31:0] ws[$]);
    exp_t e;
    int cnt[4] = '{0, 0, 0, 0};
    int base[4] = '{0, 2, 4, 5};
    int cap[4] = '{2, 2, 1, 1};
    int n = 0;
    int used = 0;
    e.vld = '0; e.ops = '0; e.osub = 0; e.olen = 0;
    foreach (ws[i]) begin
      used++;
      if (n == 6) begin e.olen = 1; break; end
      n++;
      if (cnt[ws[i][30:29]] < cap[ws[i][30:29]]) begin
        e.vld[base[ws[i][30:29]] + cnt[ws[i][30:29]]] = 1'b1;
        e.ops[32*(base[ws[i][30:29]] + cnt[ws[i][30:29]]) +: 32] = ws[i];
        cnt[ws[i][30:29]]++;
      end else e.osub = 1;
      if (ws[i][31]) break;
    end
    exp_q.push_back(e);
    for (int i = 0; i < used; i++) begin
      forever begin
        @(negedge clk);
        if (in_ready) break;
        in_valid = 0;
      end
      in_valid = 1;
      in_op = ws[i];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  // Monitor / scoreboard
  bit seen = 0, chk_clear = 0;
  int stall_left = 0;
  logic [5:0] snap_v;
  logic [191:0] snap_o;
  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_clear) begin
        chk(in_ready && !out_valid && out_vld == 0 && !out_oversub && !out_overlen,
            "R8 cleared after take", {out_valid, in_ready, out_vld}, {1'b0, 1'b1, 6'd0});
        chk_clear = 0;
      end
      if (out_valid) begin
        if (!seen) begin
          seen = 1; snap_v = out_vld; snap_o = out_ops; stall_left = stall_req;
        end
        if (stall_left > 0) begin
          chk(!in_ready, "R7 in_ready low while pending", in_ready, 0);
          chk(out_vld == snap_v && out_ops == snap_o, "R7 outputs held", out_ops, snap_o);
          stall_left--;
          out_ready = 0;
        end else begin
          if (exp_q.size() == 0) chk(0, "R1 unexpected bundle", out_vld, 0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(out_vld == e.vld, "R2/R3/R4 slot valid", out_vld, e.vld);
            chk(out_ops == e.ops, "R2/R3/R4 slot words", out_ops, e.ops);
            chk(out_oversub == e.osub, "R5 oversub flag", out_oversub, e.osub);
            chk(out_overlen == e.olen, "R6 overlen flag", out_overlen, e.olen);
          end
          out_ready = 1;
          seen = 0;
          chk_clear = 1;
        end
      end else out_ready = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] q[$];
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready && out_vld == 0 && !out_oversub && !out_overlen,
        "R9 reset state", {out_valid, in_ready, out_vld}, {1'b0, 1'b1, 6'd0});
    rst_n = 1;

    // R1, R4: single-operation bundle
    q = '{mk(1, 2'd1, 29'h11)}; send(q);
    // R2, R3: full bundle, classes interleaved, branch first
    q = '{mk(0, 2'd3, 29'h31), mk(0, 2'd0, 29'h01), mk(0, 2'd1, 29'h12),
          mk(0, 2'd0, 29'h02), mk(0, 2'd2, 29'h21), mk(1, 2'd1, 29'h13)};
    send(q);
    // R3: two memory ops keep order
    q = '{mk(0, 2'd0, 29'hA), mk(1, 2'd0, 29'hB)}; send(q);
    // R5: third memory op has no slot
    q = '{mk(0, 2'd0, 29'h41), mk(0, 2'd0, 29'h42), mk(1, 2'd0, 29'h43)}; send(q);
    // R5: second complex op dropped, then branch closes
    q = '{mk(0, 2'd2, 29'h51), mk(0, 2'd2, 29'h52), mk(1, 2'd3, 29'h53)}; send(q);
    // R6: seven words, no end marker
    q = '{mk(0, 2'd0, 29'h61), mk(0, 2'd1, 29'h62), mk(0, 2'd2, 29'h63),
          mk(0, 2'd3, 29'h64), mk(0, 2'd0, 29'h65), mk(0, 2'd1, 29'h66),
          mk(0, 2'd3, 29'h67)};
    send(q);
    // R1: next bundle after forced close starts clean
    q = '{mk(1, 2'd3, 29'h71)}; send(q);
    // R7: consumer stalls
    stall_req = 4;
    q = '{mk(0, 2'd1, 29'h81), mk(1, 2'd2, 29'h82)}; send(q);
    // R7: next bundle waits behind a stalled one
    q = '{mk(1, 2'd0, 29'h91)}; send(q);
    stall_req = 0;
    // R4: three-op bundle, unused slots zero
    q = '{mk(0, 2'd3, 29'hA1), mk(0, 2'd1, 29'hA2), mk(1, 2'd0, 29'hA3)}; send(q);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule